// File: doc/BRIEF.md
# Smart Card Character Receiver

This block takes in asynchronous characters from a smart card on one serial data line that idles high. Timing comes from outside as a half-bit-time strobe, `half_tick`, which pulses for one clock twice per elementary time unit (ETU). Each character has these fields in order:

- a start bit;
- eight data bits;
- a parity bit;
- a guard (stop) period.

The receiver samples every field at its middle. It checks parity, the stop level and line breaks. With retries enabled, it asks the line driver to signal a parity error back to the card.

Bit order and polarity follow the convention in use. In direct convention a high line is 1 and the least significant bit comes first. In inverse convention a low line is 1 and the most significant bit comes first. The convention can be fixed by an input, or it can be learned from the first character after reset.

Received bytes go into a four-entry FIFO. The FIFO raises a data-available request at a selectable fill level and a time-out request after a programmable quiet interval. The FIFO is read through a show-ahead port.

The character state machine has seven states:

- `S_IDLE` waits for a low line.
- `S_START` confirms the start bit at its middle. A high line returns it to `S_IDLE`.
- `S_DATA` collects eight bits.
- `S_PARITY` samples the parity bit.
- `S_STOP` samples the guard level, one ETU after the parity sample. From there it goes to `S_IDLE` when the guard is high and to `S_RECOVER` when it is low. On a retriable parity error it leaves half an ETU after the parity sample for `S_ERRSIG`.
- `S_ERRSIG` drives the error signal for three half-ETUs, then goes to `S_RECOVER`.
- `S_RECOVER` waits for a high line and then returns to `S_IDLE`.

Dropping `rx_en` forces `S_IDLE` from any state.

Top module: `sc_char_rx`

## Requirements
- R1: With automatic convention off, `conv_inverse`=0 decodes each line level as the bit value, least significant bit first. `conv_inverse`=1 decodes an inverted level, most significant bit first. Either way the decoded byte appears at `rd_data`.
- R2: With `auto_conv_en`=1, the first character after reset chooses the convention. A pattern that decodes to 0x3B in direct convention selects direct. A pattern that decodes to 0x3F in inverse convention selects inverse. Any other pattern sets `err_flags[5]` and leaves direct convention. The character is stored in every case, and `inverse_active` shows the chosen convention.
- R3: The FIFO holds 4 bytes and is read first-in first-out. Each `rd_en` pulse pops the byte shown on `rd_data`. `rx_full` is 1 when `rx_count` is 4. A character that completes while the FIFO is full is dropped and sets `err_flags[0]`.
- R4: For `trig_lvl` codes 0, 1 and 2, `avail_irq` is 1 while `rx_count` is at least the code plus 1. It falls when reads bring the count below that level. Code 3 never raises it.
- R5: Parity is even over the decoded data bits plus the decoded parity bit. With retries off, a mismatch sets `err_flags[1]` and the byte is still stored.
- R6: A guard level sampled low sets `err_flags[2]` and the byte is still stored. No new start is accepted until the line has returned high.
- R7: A line held low for 23 consecutive half-ETU strobes (more than one 11-ETU character) sets `err_flags[3]`.
- R8: With `retry_en`=1, a parity error within the allowed `retry_lim`+1 retries discards the byte. It raises `err_drive` for three half-ETU strobes, starting at the first strobe after the parity sample.
- R9: With `retry_en`=1, a parity error after `retry_lim`+1 retries sets `err_flags[4]`. It does not drive the line and discards the byte. Any completed character restarts the retry count.
- R10: While `retry_en`=1, `err_flags[1]`, `err_flags[2]` and `err_flags[3]` are never set.
- R11: When the FIFO holds data, `tmo_irq` rises after 2·`tmo_etu`+1 half-ETU strobes without character activity. `tmo_etu`=0 disables it. It clears only when the FIFO becomes empty.
- R12: Writing 1 to a bit of `flag_clr` clears that bit of `err_flags` and no other bit. A set in the same cycle wins.
- R13: With `rx_en`=0 the line is ignored, the FIFO is left unchanged, and the state machine is held in `S_IDLE`.
- R14: Reset empties the FIFO and clears all flags and the retry count. It returns to `S_IDLE` and re-arms convention learning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_tick | input | 1 | One-clock strobe, twice per ETU |
| sd_in | input | 1 | Serial data line, idle high |
| rx_en | input | 1 | Receiver enable |
| auto_conv_en | input | 1 | Learn the convention from the first character |
| conv_inverse | input | 1 | Fixed convention when learning is off: 1 selects inverse |
| retry_en | input | 1 | Parity-error retry enable |
| retry_lim | input | 3 | Retries allowed minus one |
| trig_lvl | input | 2 | Data-available level code |
| tmo_etu | input | 9 | Time-out length in ETU; 0 disables |
| flag_clr | input | 6 | Write-1 clear for `err_flags` |
| rd_en | input | 1 | Pop one byte |
| rd_data | output | 8 | Oldest stored byte |
| rx_count | output | 3 | Bytes stored |
| rx_empty | output | 1 | FIFO empty |
| rx_full | output | 1 | FIFO full |
| avail_irq | output | 1 | Fill level reached |
| tmo_irq | output | 1 | Receive time-out |
| err_flags | output | 6 | Bit 0 overflow, 1 parity, 2 frame, 3 break, 4 over-retry, 5 convention error |
| inverse_active | output | 1 | Convention in use: 1 inverse |
| err_drive | output | 1 | Request to pull the line low |

## Verification
A stored byte reaches the FIFO two clocks after the guard sample, about ten ETU after the start edge. Each character task returns a full ETU after that sample, so the count, data and flag checks are all taken after the result is settled. The error drive lasts exactly 12 clocks with the bench's 4-clock strobe. It is measured by counting the cycles in which it is high across one character. The time-out rises 2.5 ETU after the guard sample when `tmo_etu` is 2. It is therefore checked as low when the character task returns and as high three ETU later.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_START, S_DATA, S_PARITY, S_STOP, S_ERRSIG, S_RECOVER
    } rx_state_t;

    localparam int NFLAG  = 6;
    localparam int F_OVF  = 0;
    localparam int F_PAR  = 1;
    localparam int F_FRM  = 2;
    localparam int F_BRK  = 3;
    localparam int F_ORT  = 4;
    localparam int F_ACON = 5;
endpackage

// File: rtl/sc_rx_fifo.sv
module sc_rx_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_pop_drops_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !empty) |=> count == CW'($past(count) - 1'b1));
endmodule

// File: rtl/sc_rx_tmo.sv
module sc_rx_tmo #(
    parameter int TW  = 9,
    localparam int CW = TW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          half_tick,
    input  logic          restart,
    input  logic          armed,
    input  logic [TW-1:0] tmo_val,
    output logic          flag
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] target;

    assign target = {tmo_val, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            flag <= 1'b0;
        end else if (!armed) begin
            cnt  <= '0;
            flag <= 1'b0;
        end else if (restart) begin
            cnt <= '0;
        end else if (half_tick && !flag && tmo_val != '0) begin
            cnt <= cnt + 1'b1;
            if (CW'(cnt + 1'b1) == target) flag <= 1'b1;
        end
    end

    assert_tmo_clears_on_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !flag);
    assert_tmo_zero_disables_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(tmo_val) != '0);
endmodule

// File: rtl/sc_rx_fsm.sv
module sc_rx_fsm
    import sc_rx_pkg::*;
#(
    parameter int RETRY_W  = 3,
    parameter int CHAR_ETU = 11,
    localparam int BRK_HT  = 2 * CHAR_ETU + 1,
    localparam int LW      = $clog2(BRK_HT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               half_tick,
    input  logic               sd_in,
    input  logic               rx_en,
    input  logic               auto_conv_en,
    input  logic               conv_inverse,
    input  logic               retry_en,
    input  logic [RETRY_W-1:0] retry_lim,
    input  logic               fifo_full,
    input  logic [NFLAG-1:0]   flag_clr,
    output logic               push,
    output logic [7:0]         push_data,
    output logic               busy,
    output logic               err_drive,
    output logic               inverse_active,
    output logic [NFLAG-1:0]   flags
);
    rx_state_t        state, nstate;
    logic             ht;
    logic [2:0]       bidx;
    logic [7:0]       raw;
    logic             par_bad;
    logic [1:0]       ecnt;
    logic [RETRY_W:0] retry_cnt;
    logic             ts_pend, learned_inv;
    logic [LW-1:0]    lowcnt;
    logic [NFLAG-1:0] set_vec;
    logic             done, retry_req, char_inv, in_frame;
    logic [7:0]       decoded;

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    // raw keeps line levels with the first data bit in position 0
    assign inverse_active = auto_conv_en ? learned_inv : conv_inverse;
    assign char_inv  = (auto_conv_en && ts_pend) ? (raw == 8'h03) : inverse_active;
    assign decoded   = char_inv ? ~rev8(raw) : raw;
    assign retry_req = par_bad && retry_en && (retry_cnt <= {1'b0, retry_lim});
    assign done      = (state == S_STOP) && half_tick && ht;
    assign in_frame  = (state == S_DATA) || (state == S_PARITY) || (state == S_STOP);

    // next state
    always_comb begin
        nstate = state;
        if (!rx_en) begin
            nstate = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:    if (!sd_in) nstate = S_START;
                S_START:   if (half_tick) nstate = sd_in ? S_IDLE : S_DATA;
                S_DATA:    if (half_tick && ht && bidx == 3'd7) nstate = S_PARITY;
                S_PARITY:  if (half_tick && ht) nstate = S_STOP;
                S_STOP:    if (half_tick) begin
                               if (!ht && retry_req) nstate = S_ERRSIG;
                               else if (ht)          nstate = sd_in ? S_IDLE : S_RECOVER;
                           end
                S_ERRSIG:  if (half_tick && ecnt == 2'd2) nstate = S_RECOVER;
                S_RECOVER: if (sd_in) nstate = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // flag set conditions
    always_comb begin
        set_vec = '0;
        if (done) begin
            if (par_bad && retry_en) begin
                set_vec[F_ORT] = 1'b1;
            end else begin
                set_vec[F_OVF]  = fifo_full;
                set_vec[F_PAR]  = par_bad;
                set_vec[F_FRM]  = !sd_in && !retry_en;
                set_vec[F_ACON] = auto_conv_en && ts_pend && raw != 8'h3B && raw != 8'h03;
            end
        end
        if (rx_en && half_tick && !sd_in && !retry_en && lowcnt == LW'(BRK_HT - 1))
            set_vec[F_BRK] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ht <= 1'b0;  bidx <= '0;  raw <= '0;  par_bad <= 1'b0;
            ecnt <= '0;  retry_cnt <= '0;  ts_pend <= 1'b1;  learned_inv <= 1'b0;
            lowcnt <= '0;  flags <= '0;  push <= 1'b0;  push_data <= '0;
        end else begin
            push <= 1'b0;
            if (nstate != state)       ht <= 1'b0;
            else if (half_tick && in_frame) ht <= ~ht;
            if (state == S_START) bidx <= '0;
            if (state == S_DATA && half_tick && ht) begin
                raw[bidx] <= sd_in;
                bidx      <= bidx + 3'd1;
            end
            if (state == S_PARITY && half_tick && ht)
                par_bad <= (^raw) ^ sd_in ^ char_inv;
            if (state == S_STOP && half_tick && !ht && retry_req)
                retry_cnt <= retry_cnt + 1'b1;
            if (state == S_ERRSIG) begin
                if (half_tick) ecnt <= ecnt + 2'd1;
            end else begin
                ecnt <= '0;
            end
            if (done) begin
                retry_cnt <= '0;
                if (!(par_bad && retry_en)) begin
                    push      <= !fifo_full;
                    push_data <= decoded;
                    if (auto_conv_en && ts_pend) begin
                        ts_pend     <= 1'b0;
                        learned_inv <= (raw == 8'h03);
                    end
                end
            end
            if (sd_in || !rx_en)                              lowcnt <= '0;
            else if (half_tick && lowcnt != LW'(BRK_HT))      lowcnt <= lowcnt + 1'b1;
            flags <= (flags & ~flag_clr) | set_vec;
        end
    end

    // outputs
    always_comb begin
        err_drive = (state == S_ERRSIG);
        busy      = (state != S_IDLE);
    end

    assert_retry_hides_errors_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_en && $past(retry_en)) |->
            !($rose(flags[F_PAR]) || $rose(flags[F_FRM]) || $rose(flags[F_BRK])));
    assert_drive_follows_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_drive) |-> $past(state) == S_STOP);
    assert_no_push_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !$past(fifo_full));
endmodule

// File: rtl/sc_char_rx.sv
module sc_char_rx
    import sc_rx_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int TMO_W      = 9,
    parameter int RETRY_W    = 3,
    parameter int CHAR_ETU   = 11,
    localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               half_tick,
    input  logic               sd_in,
    input  logic               rx_en,
    input  logic               auto_conv_en,
    input  logic               conv_inverse,
    input  logic               retry_en,
    input  logic [RETRY_W-1:0] retry_lim,
    input  logic [1:0]         trig_lvl,
    input  logic [TMO_W-1:0]   tmo_etu,
    input  logic [NFLAG-1:0]   flag_clr,
    input  logic               rd_en,
    output logic [7:0]         rd_data,
    output logic [CW-1:0]      rx_count,
    output logic               rx_empty,
    output logic               rx_full,
    output logic               avail_irq,
    output logic               tmo_irq,
    output logic [NFLAG-1:0]   err_flags,
    output logic               inverse_active,
    output logic               err_drive
);
    logic       push, busy;
    logic [7:0] push_data;

    sc_rx_fsm #(.RETRY_W(RETRY_W), .CHAR_ETU(CHAR_ETU)) u_fsm (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .sd_in(sd_in),
        .rx_en(rx_en), .auto_conv_en(auto_conv_en), .conv_inverse(conv_inverse),
        .retry_en(retry_en), .retry_lim(retry_lim), .fifo_full(rx_full),
        .flag_clr(flag_clr), .push(push), .push_data(push_data), .busy(busy),
        .err_drive(err_drive), .inverse_active(inverse_active), .flags(err_flags)
    );

    sc_rx_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .wdata(push_data), .pop(rd_en),
        .rdata(rd_data), .count(rx_count), .empty(rx_empty), .full(rx_full)
    );

    sc_rx_tmo #(.TW(TMO_W)) u_tmo (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .restart(push || busy),
        .armed(!rx_empty), .tmo_val(tmo_etu), .flag(tmo_irq)
    );

    assign avail_irq = (trig_lvl != 2'd3) && (rx_count > CW'(trig_lvl));

    assert_avail_needs_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        avail_irq |-> !rx_empty);
endmodule

// File: tb/sc_char_rx_bench.sv
module sc_char_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] hc = 2'd0;
    logic       sd_in = 1'b1, rx_en = 1'b1, auto_conv_en = 1'b0, conv_inverse = 1'b0;
    logic       retry_en = 1'b0, rd_en = 1'b0;
    logic [2:0] retry_lim = 3'd0;
    logic [1:0] trig_lvl = 2'd0;
    logic [8:0] tmo_etu = 9'd0;
    logic [5:0] flag_clr = 6'd0;
    logic [7:0] rd_data;
    logic [2:0] rx_count;
    logic       rx_empty, rx_full, avail_irq, tmo_irq, inverse_active, err_drive;
    logic [5:0] err_flags;
    logic       half_tick;
    int         checks = 0, errors = 0, drv_total = 0;

    always #4 clk = ~clk;
    always @(negedge clk) hc <= hc + 2'd1;
    assign half_tick = (hc == 2'd0);
    always @(posedge clk) if (err_drive) drv_total <= drv_total + 1;

    sc_char_rx u_sc_char_rx (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .sd_in(sd_in), .rx_en(rx_en),
        .auto_conv_en(auto_conv_en), .conv_inverse(conv_inverse), .retry_en(retry_en),
        .retry_lim(retry_lim), .trig_lvl(trig_lvl), .tmo_etu(tmo_etu), .flag_clr(flag_clr),
        .rd_en(rd_en), .rd_data(rd_data), .rx_count(rx_count), .rx_empty(rx_empty),
        .rx_full(rx_full), .avail_irq(avail_irq), .tmo_irq(tmo_irq), .err_flags(err_flags),
        .inverse_active(inverse_active), .err_drive(err_drive)
    );

    // {inverse, data}
    localparam logic [8:0] VEC [6] = '{9'h0A5, 9'h000, 9'h0FF, 9'h1A5, 9'h13C, 9'h181};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic line(input logic v, input int etus);
        sd_in = v;
        repeat (8 * etus) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic inv, input logic badpar,
                        input logic badstop);
        logic [7:0] lb;
        logic       p;
        for (int i = 0; i < 8; i++) lb[i] = inv ? ~d[7-i] : d[i];
        p = inv ? ~(^d) : (^d);
        if (badpar) p = ~p;
        line(1'b0, 1);
        for (int i = 0; i < 8; i++) line(lb[i], 1);
        line(p, 1);
        line(!badstop, 1);
        line(1'b1, 1);
    endtask

    task automatic pop(output logic [7:0] v);
        v = rd_data;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic clr(input logic [5:0] m);
        flag_clr = m;
        @(negedge clk);
        flag_clr = 6'd0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int d0;
        do_reset();
        // R14 reset state
        chk("R14 empty", rx_empty, 1);
        chk("R14 count", rx_count, 0);
        chk("R14 flags", err_flags, 0);
        chk("R14 drive", err_drive, 0);
        chk("R14 avail", avail_irq, 0);

        // R1 table of fixed-convention characters
        for (int i = 0; i < 6; i++) begin
            conv_inverse = VEC[i][8];
            send(VEC[i][7:0], VEC[i][8], 1'b0, 1'b0);
            chk("R4 avail level1", avail_irq, 1);
            pop(v);
            chk("R1 decode", v, VEC[i][7:0]);
            chk("R1 flags", err_flags, 0);
        end
        conv_inverse = 1'b0;

        // R4 level 2
        trig_lvl = 2'd1;
        send(8'h11, 0, 0, 0);
        chk("R4 below", avail_irq, 0);
        send(8'h22, 0, 0, 0);
        chk("R4 reached", avail_irq, 1);
        pop(v);
        chk("R4 drops", avail_irq, 0);
        pop(v);

        // R3 fill, overflow, order; code 3 never raises
        trig_lvl = 2'd3;
        send(8'h11, 0, 0, 0); send(8'h22, 0, 0, 0);
        send(8'h33, 0, 0, 0); send(8'h44, 0, 0, 0);
        chk("R3 full", rx_full, 1);
        chk("R4 reserved", avail_irq, 0);
        send(8'h55, 0, 0, 0);
        chk("R3 overflow flag", err_flags, 6'h01);
        chk("R3 count held", rx_count, 4);
        for (int i = 0; i < 4; i++) begin
            pop(v);
            chk("R3 order", v, 8'h11 * (i + 1));
        end
        chk("R3 empty", rx_empty, 1);
        clr(6'h01);
        trig_lvl = 2'd0;

        // R5 parity, R6 frame, R12 selective clear
        send(8'h42, 0, 1, 1);
        chk("R5 R6 flags", err_flags, 6'h06);
        clr(6'h02);
        chk("R12 clear one", err_flags, 6'h04);
        pop(v);
        chk("R5 stored", v, 8'h42);
        clr(6'h04);
        chk("R12 cleared", err_flags, 0);

        // R7 break
        line(1'b0, 30);
        line(1'b1, 2);
        chk("R7 break", err_flags[3], 1);
        pop(v);
        clr(6'h3F);

        // R8 R9 R10 retry
        retry_en = 1'b1;
        retry_lim = 3'd0;
        d0 = drv_total;
        send(8'h5A, 0, 1, 0);
        chk("R8 drive len", drv_total - d0, 12);
        chk("R8 discarded", rx_count, 0);
        chk("R10 no parity flag", err_flags, 0);
        d0 = drv_total;
        send(8'h5A, 0, 1, 0);
        chk("R9 no drive", drv_total - d0, 0);
        chk("R9 over flag", err_flags, 6'h10);
        chk("R9 discarded", rx_count, 0);
        clr(6'h10);
        send(8'h5A, 0, 0, 0);
        pop(v);
        chk("R9 good stored", v, 8'h5A);
        d0 = drv_total;
        send(8'h5A, 0, 1, 0);
        chk("R9 count restarted", drv_total - d0, 12);
        send(8'h77, 0, 0, 1);
        chk("R10 no frame flag", err_flags, 0);
        pop(v);
        chk("R10 stored", v, 8'h77);
        retry_en = 1'b0;

        // R11 time-out
        tmo_etu = 9'd2;
        send(8'h31, 0, 0, 0);
        chk("R11 not yet", tmo_irq, 0);
        repeat (24) @(negedge clk);
        chk("R11 fired", tmo_irq, 1);
        pop(v);
        chk("R11 clears on empty", tmo_irq, 0);
        tmo_etu = 9'd0;
        send(8'h32, 0, 0, 0);
        repeat (320) @(negedge clk);
        chk("R11 disabled", tmo_irq, 0);
        pop(v);

        // R13 receiver off
        rx_en = 1'b0;
        send(8'h99, 0, 0, 0);
        chk("R13 ignored", rx_count, 0);
        chk("R13 no flags", err_flags, 0);
        rx_en = 1'b1;

        // R2 learning, inverse
        auto_conv_en = 1'b1;
        do_reset();
        send(8'h3F, 1, 0, 0);
        chk("R2 inverse chosen", inverse_active, 1);
        pop(v);
        chk("R2 inverse byte", v, 8'h3F);
        send(8'hA5, 1, 0, 0);
        pop(v);
        chk("R2 inverse follows", v, 8'hA5);
        // R2 direct
        send(8'h11, 1, 0, 0);
        do_reset();
        chk("R14 emptied", rx_count, 0);
        send(8'h3B, 0, 0, 0);
        chk("R2 direct chosen", inverse_active, 0);
        pop(v);
        chk("R2 direct byte", v, 8'h3B);
        chk("R2 no error", err_flags, 0);
        // R2 bad first byte
        do_reset();
        send(8'h55, 0, 0, 0);
        chk("R2 error flag", err_flags, 6'h20);
        pop(v);
        chk("R2 stored", v, 8'h55);
        auto_conv_en = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule